// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register decoder of a host-facing storage controller. It receives every write that lands in the doorbell window. The window starts at a fixed base offset and holds one 32-bit doorbell every 4 bytes. Even slots carry a new submission-queue tail. Odd slots carry a new completion-queue head. For each write the block works out the queue kind and the queue number, then takes the new pointer from the low bits of the data. It checks the pointer against the queue's existence bit and its configured depth.

An accepted write updates the stored pointer of that queue. It also raises a one-cycle update strobe that carries the kind, the id and the pointer value. A rejected write changes nothing. It raises a one-cycle error strobe with a cause code that says why it was dropped. The command fetch engine and the completion poster read the stored pointers through a combinational select port.

Top module: `qdb_decoder`

## Requirements
- R1: After reset, every stored submission tail and completion head is 0, and both `upd_vld` and `err_vld` are low.
- R2: For an aligned write at or above the base offset, bit 2 of the offset from the base selects the kind: 0 is a submission tail (`upd_is_cq`=0), and 1 is a completion head (`upd_is_cq`=1).
- R3: The queue id is the offset from the base shifted right by 3, for both kinds.
- R4: The new pointer is bits 15:0 of the write data. Bits 31:16 have no effect on the stored or reported value.
- R5: A write whose address bits 1:0 are not zero is dropped with cause 1 (misaligned).
- R6: An aligned write below the base offset is dropped with cause 2 (outside the window).
- R7: A write to a queue whose existence bit is clear, or whose id is at or above NUM_Q, is dropped with cause 3 (no such queue).
- R8: A pointer greater than or equal to the queue's configured size is dropped with cause 4 (out of range), and the stored pointer keeps its old value.
- R9: An accepted write updates the stored pointer at the clock edge that samples it. In the following cycle only, `upd_vld` is high with the kind, id and pointer of that write, and `err_vld` is low.
- R10: When several faults apply, the cause reported is the first one in this order: misaligned, outside the window, no such queue, out of range.
- R11: A cycle with no write leaves both strobes low in the next cycle and leaves every stored pointer unchanged.
- R12: `sel_sq_tail` and `sel_cq_head` show, in the same cycle, the stored pointers of the queue selected by `sel_qid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write into the doorbell window this cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| sq_valid | input | NUM_Q | Submission queue existence bits |
| cq_valid | input | NUM_Q | Completion queue existence bits |
| sq_size | input | NUM_Q*PTR_W | Submission queue depths, queue i at bits [i*PTR_W +: PTR_W] |
| cq_size | input | NUM_Q*PTR_W | Completion queue depths, same packing |
| sel_qid | input | QID_W | Queue whose stored pointers are shown |
| sel_sq_tail | output | PTR_W | Stored submission tail of `sel_qid` |
| sel_cq_head | output | PTR_W | Stored completion head of `sel_qid` |
| upd_vld | output | 1 | One-cycle strobe for an accepted write |
| upd_is_cq | output | 1 | Kind of the last accepted write, 1 = completion head |
| upd_qid | output | QID_W | Queue id of the last accepted write |
| upd_ptr | output | PTR_W | Pointer of the last accepted write |
| err_vld | output | 1 | One-cycle strobe for a dropped write |
| err_cause | output | 3 | Drop cause while `err_vld` is high, 0 otherwise |

## Verification
The decode is driven with submission slots and completion slots on different queues, so that a swapped kind bit or an off-by-one id shows up as a wrong `upd_is_cq`, `upd_qid` or stored pointer. The data words carry nonzero upper halves, which exposes any leak of bits 31:16 into the pointer. Pointers one below and exactly at a queue's depth separate an accept from a range drop at the boundary. Writes that carry two faults at once, such as an absent queue with an oversized pointer or a misaligned write below the window, check the order in which causes are chosen.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

  typedef enum logic [2:0] {
    DB_OK       = 3'd0,
    DB_MISALIGN = 3'd1,
    DB_OUTSIDE  = 3'd2,
    DB_NOQUEUE  = 3'd3,
    DB_RANGE    = 3'd4
  } db_cause_e;

  typedef struct packed {
    logic misalign;
    logic outside;
    logic is_cq;
  } db_slot_t;

endpackage

// File: rtl/qdb_addr_decode.sv
module qdb_addr_decode
  import qdb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000,
  localparam int QFULL_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0]  addr,
  output db_slot_t           slot,
  output logic [QFULL_W-1:0] qid_full
);

  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset        = addr - BASE_L;
    slot.misalign = (addr[1:0] != 2'b00);
    slot.outside  = (addr < BASE_L);
    slot.is_cq    = offset[2];
    qid_full      = offset[ADDR_W-1:3];
  end

endmodule

// File: rtl/qdb_check.sv
module qdb_check
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16,
  localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int QFULL_W = ADDR_W - 3
) (
  input  db_slot_t               slot,
  input  logic [QFULL_W-1:0]     qid_full,
  input  logic [PTR_W-1:0]       new_ptr,
  input  logic [NUM_Q-1:0]       sq_valid,
  input  logic [NUM_Q-1:0]       cq_valid,
  input  logic [NUM_Q*PTR_W-1:0] sq_size,
  input  logic [NUM_Q*PTR_W-1:0] cq_size,
  output logic                   accept,
  output db_cause_e              cause,
  output logic [QID_W-1:0]       qid
);

  localparam logic [QFULL_W-1:0] NQ_L = QFULL_W'(NUM_Q);

  logic             id_in_range;
  logic             q_exists;
  logic [PTR_W-1:0] q_depth;

  // Select the existence bit and depth of the addressed queue and kind.
  always_comb begin
    id_in_range = (qid_full < NQ_L);
    qid         = qid_full[QID_W-1:0];
    q_exists    = 1'b0;
    q_depth     = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (id_in_range && (qid_full == QFULL_W'(i))) begin
        q_exists = slot.is_cq ? cq_valid[i] : sq_valid[i];
        q_depth  = slot.is_cq ? cq_size[i*PTR_W +: PTR_W]
                              : sq_size[i*PTR_W +: PTR_W];
      end
    end
  end

  // Fault priority: alignment, window, existence, depth.
  always_comb begin
    if (slot.misalign) begin
      cause = DB_MISALIGN;
    end else if (slot.outside) begin
      cause = DB_OUTSIDE;
    end else if (!q_exists) begin
      cause = DB_NOQUEUE;
    end else if (new_ptr >= q_depth) begin
      cause = DB_RANGE;
    end else begin
      cause = DB_OK;
    end
    accept = (cause == DB_OK);
  end

endmodule

// File: rtl/qdb_ptr_store.sv
module qdb_ptr_store #(
  parameter int NUM_Q = 8,
  parameter int PTR_W = 16,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic             wr_is_cq,
  input  logic [QID_W-1:0] wr_qid,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [QID_W-1:0] rd_qid,
  output logic [PTR_W-1:0] rd_sq_tail,
  output logic [PTR_W-1:0] rd_cq_head
);

  logic [PTR_W-1:0] sq_tail_q [NUM_Q];
  logic [PTR_W-1:0] cq_head_q [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    logic sq_en;
    logic cq_en;

    always_comb begin
      sq_en = wr_acc && !wr_is_cq && (wr_qid == QID_W'(g));
      cq_en = wr_acc &&  wr_is_cq && (wr_qid == QID_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sq_tail_q[g] <= '0;
      end else if (sq_en) begin
        sq_tail_q[g] <= wr_ptr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cq_head_q[g] <= '0;
      end else if (cq_en) begin
        cq_head_q[g] <= wr_ptr;
      end
    end
  end

  always_comb begin
    rd_sq_tail = '0;
    rd_cq_head = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (rd_qid == QID_W'(i)) begin
        rd_sq_tail = sq_tail_q[i];
        rd_cq_head = cq_head_q[i];
      end
    end
  end

endmodule

// File: rtl/qdb_decoder.sv
module qdb_decoder
  import qdb_pkg::*;
#(
  parameter int NUM_Q   = 8,
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int QFULL_W = ADDR_W - 3,
  localparam int DATA_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_Q-1:0]       sq_valid,
  input  logic [NUM_Q-1:0]       cq_valid,
  input  logic [NUM_Q*PTR_W-1:0] sq_size,
  input  logic [NUM_Q*PTR_W-1:0] cq_size,
  input  logic [QID_W-1:0]       sel_qid,
  output logic [PTR_W-1:0]       sel_sq_tail,
  output logic [PTR_W-1:0]       sel_cq_head,
  output logic                   upd_vld,
  output logic                   upd_is_cq,
  output logic [QID_W-1:0]       upd_qid,
  output logic [PTR_W-1:0]       upd_ptr,
  output logic                   err_vld,
  output logic [2:0]             err_cause
);

  db_slot_t           slot;
  logic [QFULL_W-1:0] qid_full;
  logic [QID_W-1:0]   chk_qid;
  logic               chk_accept;
  db_cause_e          chk_cause;
  logic [PTR_W-1:0]   new_ptr;
  logic               wr_acc;
  logic               wr_rej;
  logic [DATA_W-PTR_W-1:0] unused_data_hi;

  assign new_ptr        = wr_data[PTR_W-1:0];
  assign unused_data_hi = wr_data[DATA_W-1:PTR_W];

  qdb_addr_decode #(
    .ADDR_W  (ADDR_W),
    .DB_BASE (DB_BASE)
  ) u_addr_decode (
    .addr     (wr_addr),
    .slot     (slot),
    .qid_full (qid_full)
  );

  qdb_check #(
    .NUM_Q  (NUM_Q),
    .PTR_W  (PTR_W),
    .ADDR_W (ADDR_W)
  ) u_check (
    .slot     (slot),
    .qid_full (qid_full),
    .new_ptr  (new_ptr),
    .sq_valid (sq_valid),
    .cq_valid (cq_valid),
    .sq_size  (sq_size),
    .cq_size  (cq_size),
    .accept   (chk_accept),
    .cause    (chk_cause),
    .qid      (chk_qid)
  );

  assign wr_acc = wr_en &&  chk_accept;
  assign wr_rej = wr_en && !chk_accept;

  qdb_ptr_store #(
    .NUM_Q (NUM_Q),
    .PTR_W (PTR_W)
  ) u_ptr_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_acc     (wr_acc),
    .wr_is_cq   (slot.is_cq),
    .wr_qid     (chk_qid),
    .wr_ptr     (new_ptr),
    .rd_qid     (sel_qid),
    .rd_sq_tail (sel_sq_tail),
    .rd_cq_head (sel_cq_head)
  );

  // Output stage: next-state logic.
  logic             upd_vld_d;
  logic             err_vld_d;
  logic [2:0]       err_cause_d;
  logic             upd_is_cq_d;
  logic [QID_W-1:0] upd_qid_d;
  logic [PTR_W-1:0] upd_ptr_d;

  always_comb begin
    upd_vld_d   = wr_acc;
    err_vld_d   = wr_rej;
    err_cause_d = wr_rej ? chk_cause : DB_OK;
    upd_is_cq_d = upd_is_cq;
    upd_qid_d   = upd_qid;
    upd_ptr_d   = upd_ptr;
    if (wr_acc) begin
      upd_is_cq_d = slot.is_cq;
      upd_qid_d   = chk_qid;
      upd_ptr_d   = new_ptr;
    end
  end

  // Output stage: registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_vld   <= 1'b0;
      err_vld   <= 1'b0;
      err_cause <= 3'd0;
      upd_is_cq <= 1'b0;
      upd_qid   <= '0;
      upd_ptr   <= '0;
    end else begin
      upd_vld   <= upd_vld_d;
      err_vld   <= err_vld_d;
      err_cause <= err_cause_d;
      upd_is_cq <= upd_is_cq_d;
      upd_qid   <= upd_qid_d;
      upd_ptr   <= upd_ptr_d;
    end
  end

endmodule

// File: rtl/qdb_decoder_chk.sv
module qdb_decoder_chk #(
  parameter int NUM_Q  = 8,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [QID_W-1:0]  sel_qid,
  input logic [PTR_W-1:0]  sel_sq_tail,
  input logic [PTR_W-1:0]  sel_cq_head,
  input logic              upd_vld,
  input logic              upd_is_cq,
  input logic [QID_W-1:0]  upd_qid,
  input logic [PTR_W-1:0]  upd_ptr,
  input logic              err_vld,
  input logic [2:0]        err_cause
);

  // R9
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_vld && err_vld));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!upd_vld && !err_vld));

  // R5
  misalign_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr[1:0] != 2'b00)) |=> (err_vld && err_cause == 3'd1));

  // R9
  sq_store_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && !upd_is_cq && sel_qid == upd_qid) |-> (sel_sq_tail == upd_ptr));

  // R9
  cq_store_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_is_cq && sel_qid == upd_qid) |-> (sel_cq_head == upd_ptr));

  // R8
  drop_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && $stable(sel_qid)) |-> ($stable(sel_sq_tail) && $stable(sel_cq_head)));

  // R10
  cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (err_cause >= 3'd1 && err_cause <= 3'd4));

  // R1
  cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |-> (err_cause == 3'd0));

endmodule

bind qdb_decoder qdb_decoder_chk #(
  .NUM_Q  (NUM_Q),
  .PTR_W  (PTR_W),
  .ADDR_W (ADDR_W)
) u_qdb_decoder_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .sel_qid     (sel_qid),
  .sel_sq_tail (sel_sq_tail),
  .sel_cq_head (sel_cq_head),
  .upd_vld     (upd_vld),
  .upd_is_cq   (upd_is_cq),
  .upd_qid     (upd_qid),
  .upd_ptr     (upd_ptr),
  .err_vld     (err_vld),
  .err_cause   (err_cause)
);

// File: tb/qdb_decoder_bench.sv
module qdb_decoder_bench;

  localparam int NUM_Q = 8;
  localparam int PTR_W = 16;
  localparam int ADDR_W = 16;
  localparam int QID_W = 3;

  logic                   clk;
  logic                   rst_n;
  logic                   wr_en;
  logic [ADDR_W-1:0]      wr_addr;
  logic [31:0]            wr_data;
  logic [NUM_Q-1:0]       sq_valid;
  logic [NUM_Q-1:0]       cq_valid;
  logic [NUM_Q*PTR_W-1:0] sq_size;
  logic [NUM_Q*PTR_W-1:0] cq_size;
  logic [QID_W-1:0]       sel_qid;
  logic [PTR_W-1:0]       sel_sq_tail;
  logic [PTR_W-1:0]       sel_cq_head;
  logic                   upd_vld;
  logic                   upd_is_cq;
  logic [QID_W-1:0]       upd_qid;
  logic [PTR_W-1:0]       upd_ptr;
  logic                   err_vld;
  logic [2:0]             err_cause;

  int total = 0;
  int bad = 0;

  qdb_decoder u_qdb_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_valid(sq_valid), .cq_valid(cq_valid), .sq_size(sq_size), .cq_size(cq_size),
    .sel_qid(sel_qid), .sel_sq_tail(sel_sq_tail), .sel_cq_head(sel_cq_head),
    .upd_vld(upd_vld), .upd_is_cq(upd_is_cq), .upd_qid(upd_qid), .upd_ptr(upd_ptr),
    .err_vld(err_vld), .err_cause(err_cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one write at a falling edge, sample its result at the next falling edge.
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_err(input string req, input logic [ADDR_W-1:0] a,
                            input logic [31:0] d, input int cause);
    do_write(a, d);
    check(req, upd_vld, 0);
    check(req, err_vld, 1);
    check(req, err_cause, cause);
  endtask

  task automatic test_reset();
    for (int i = 0; i < NUM_Q; i++) begin
      sel_qid = QID_W'(i);
      #1;
      check("R1 sq tail", sel_sq_tail, 0);
      check("R1 cq head", sel_cq_head, 0);
    end
    check("R1 upd_vld", upd_vld, 0);
    check("R1 err_vld", err_vld, 0);
  endtask

  task automatic test_sq_accept();
    sel_qid = 3'd3;
    do_write(16'h1018, 32'hABCD_0005);
    check("R9 upd_vld", upd_vld, 1);
    check("R9 err_vld", err_vld, 0);
    check("R2 sq kind", upd_is_cq, 0);
    check("R3 sq qid", upd_qid, 3);
    check("R4 sq ptr", upd_ptr, 5);
    check("R12 sq tail", sel_sq_tail, 5);
    check("R2 cq head untouched", sel_cq_head, 0);
    @(negedge clk);
    check("R9 one-cycle strobe", upd_vld, 0);
  endtask

  task automatic test_cq_accept();
    sel_qid = 3'd5;
    do_write(16'h102C, 32'hFFFF_0002);
    check("R9 upd_vld cq", upd_vld, 1);
    check("R2 cq kind", upd_is_cq, 1);
    check("R3 cq qid", upd_qid, 5);
    check("R4 cq ptr", upd_ptr, 2);
    check("R12 cq head", sel_cq_head, 2);
    check("R2 sq tail untouched", sel_sq_tail, 0);
  endtask

  task automatic test_bounds();
    // queue 0 submission depth is 8
    sel_qid = 3'd0;
    do_write(16'h1000, 32'h0001_0007);
    check("R8 below depth accepted", upd_vld, 1);
    check("R8 stored 7", sel_sq_tail, 7);
    expect_err("R8 at depth", 16'h1000, 32'h0000_0008, 4);
    check("R8 stored kept", sel_sq_tail, 7);
    // queue 1 completion depth is 5
    sel_qid = 3'd1;
    expect_err("R8 cq above depth", 16'h100C, 32'h0000_0009, 4);
    check("R8 cq head kept", sel_cq_head, 0);
  endtask

  task automatic test_faults();
    sel_qid = 3'd3;
    expect_err("R5 misaligned", 16'h1019, 32'h1, 1);
    expect_err("R5 misaligned 2", 16'h1002, 32'h1, 1);
    check("R5 stored kept", sel_sq_tail, 5);
    expect_err("R6 below base", 16'h0FFC, 32'h1, 2);
    expect_err("R7 sq absent", 16'h1038, 32'h1, 3);
    expect_err("R7 cq absent", 16'h1014, 32'h1, 3);
    expect_err("R7 id too large", 16'h1040, 32'h1, 3);
    expect_err("R10 absent over range", 16'h1038, 32'hFFFF, 3);
    expect_err("R10 misalign over outside", 16'h0FFD, 32'h1, 1);
  endtask

  task automatic test_idle();
    sel_qid = 3'd3;
    wr_addr = 16'h1018;
    wr_data = 32'h9;
    repeat (3) @(negedge clk);
    check("R11 no upd", upd_vld, 0);
    check("R11 no err", err_vld, 0);
    check("R11 state kept", sel_sq_tail, 5);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sel_qid = '0;
    sq_valid = 8'b0111_1111;
    cq_valid = 8'b1111_1011;
    for (int i = 0; i < NUM_Q; i++) begin
      sq_size[i*PTR_W +: PTR_W] = PTR_W'(8 + i);
      cq_size[i*PTR_W +: PTR_W] = PTR_W'(4 + i);
    end
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_sq_accept();
    test_cq_accept();
    test_bounds();
    test_faults();
    test_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule